// File: doc/BRIEF.md
# Tiled View Address Generator

This block turns a pixel coordinate into an address in a tiled memory window. A request carries a tiling format (8-bit, 16-bit or 32-bit tiled elements, or whole-page mode), a three-bit view orientation, and an X/Y pixel coordinate. The block checks the coordinate against the range allowed for that format. It then applies the mirroring and axis swap that the orientation asks for, scales the linear offset by the element size, and places the orientation and format codes in the top address bits. The same cycle also produces the row stride in bytes for that format and orientation.

A second path in the same request turns the origin of an allocated block, given in slots, into a pixel origin. It uses the slot width and slot height of the selected format. All results are registered and appear one cycle after the request strobe, together with an output valid. The outputs hold their last values while no request is presented.

With the default parameters the window is 2^14 units wide and 2^13 units high, and a slot is 2^6 by 2^6 units.

Top module: `tv_addr_gen`

## Requirements
- R1: `out_valid` is high in exactly the cycle after a cycle with `in_valid` high. All other outputs are registered and take their new values at that same edge.
- R2: For an in-range request, `addr[31:29]` equals `orient` and `addr[28:27]` equals `fmt`. The format codes are 0 = 8-bit, 1 = 16-bit, 2 = 32-bit, 3 = page. The view codes are 0 = 0°, 1 = 180° mirrored, 2 = 0° mirrored, 3 = 180°, 4 = 270° mirrored, 5 = 270°, 6 = 90°, 7 = 90° mirrored.
- R3: The unused X/Y bit counts are (0,0) for 8-bit, (0,1) for 16-bit, (1,1) for 32-bit and (6,6) for page. The X width is 14 minus the unused X count and the Y width is 13 minus the unused Y count. If X exceeds 2^Xwidth−1 or Y exceeds 2^Ywidth−1, `coord_err` is 1 and `addr` is 0.
- R4: `orient[0]` replaces X with X XOR its full mask, and `orient[1]` does the same for Y with its mask.
- R5: When `orient[2]` is 0 the linear offset is (Y << Xwidth) + X. When it is 1 the offset is (X << Ywidth) + Y. Mirroring is applied before this step.
- R6: `addr[26:0]` is the linear offset shifted left by (unused X + unused Y).
- R7: `stride` is 1 << (13 + unused X) when `orient[2]` is 1, and 1 << (14 + unused Y) otherwise. It is computed even for out-of-range coordinates.
- R8: `pix_x` is `slot_x` << (6 − unused X) and `pix_y` is `slot_y` << (6 − unused Y).
- R9: While `rst_n` is low, every output is 0.
- R10: While `in_valid` is low, `addr`, `coord_err`, `stride`, `pix_x` and `pix_y` keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request strobe |
| fmt | input | 2 | Tiling format code |
| orient | input | 3 | View orientation: [0] X mirror, [1] Y mirror, [2] axis swap |
| x_in | input | 16 | Pixel X coordinate |
| y_in | input | 16 | Pixel Y coordinate |
| slot_x | input | 8 | Block origin X in slots |
| slot_y | input | 7 | Block origin Y in slots |
| out_valid | output | 1 | Results valid, one cycle after the request |
| addr | output | 32 | Tiled-space address |
| coord_err | output | 1 | Coordinate out of range for the format |
| stride | output | 32 | Row stride in bytes |
| pix_x | output | 14 | Block origin X in pixels |
| pix_y | output | 13 | Block origin Y in pixels |

## Verification
Any fault in the format geometry, masks or shifts shows in `addr` at the cycle after the request. Errors in the mirroring, the axis swap or the scale show up as a wrong low-order pattern. Errors in the field placement show up as wrong top bits. A wrong width or mask shows first as a misjudged range error on a coordinate one past the limit, and the vector table includes such coordinates. A stuck or leaking output register shows up as a wrong `out_valid` timing, or as outputs that change while no request is presented.

// File: rtl/tv_pkg.sv
package tv_pkg;

  typedef enum logic [1:0] {
    FMT_E8   = 2'd0,
    FMT_E16  = 2'd1,
    FMT_E32  = 2'd2,
    FMT_PAGE = 2'd3
  } tv_fmt_e;

  // Low X-address bits absorbed by the element size of a format.
  function automatic logic [5:0] spare_x(input logic [1:0] f, input int slot_bits);
    case (tv_fmt_e'(f))
      FMT_E8:  return 6'd0;
      FMT_E16: return 6'd0;
      FMT_E32: return 6'd1;
      default: return 6'(slot_bits);
    endcase
  endfunction

  // Low Y-address bits absorbed by the element size of a format.
  function automatic logic [5:0] spare_y(input logic [1:0] f, input int slot_bits);
    case (tv_fmt_e'(f))
      FMT_E8:  return 6'd0;
      FMT_E16: return 6'd1;
      FMT_E32: return 6'd1;
      default: return 6'(slot_bits);
    endcase
  endfunction

endpackage

// File: rtl/tv_geom.sv
module tv_geom #(
  parameter int CW_BITS = 14,
  parameter int CH_BITS = 13,
  parameter int SW_BITS = 6,
  parameter int SH_BITS = 6,
  localparam int OFF_W  = CW_BITS + CH_BITS
) (
  input  logic [1:0]       fmt,
  output logic [5:0]       ux,
  output logic [5:0]       uy,
  output logic [5:0]       xw,
  output logic [5:0]       yw,
  output logic [5:0]       align,
  output logic [OFF_W-1:0] xmask,
  output logic [OFF_W-1:0] ymask
);
  import tv_pkg::*;

  always_comb begin
    ux    = spare_x(fmt, SW_BITS);
    uy    = spare_y(fmt, SH_BITS);
    xw    = 6'(CW_BITS) - ux;
    yw    = 6'(CH_BITS) - uy;
    align = ux + uy;
    xmask = (OFF_W'(1) << xw) - OFF_W'(1);
    ymask = (OFF_W'(1) << yw) - OFF_W'(1);
  end
endmodule

// File: rtl/tv_coord_map.sv
module tv_coord_map #(
  parameter int COORD_W = 16,
  parameter int CW_BITS = 14,
  parameter int CH_BITS = 13,
  localparam int OFF_W  = CW_BITS + CH_BITS
) (
  input  logic [COORD_W-1:0] x_in,
  input  logic [COORD_W-1:0] y_in,
  input  logic [2:0]         orient,
  input  logic [5:0]         xw,
  input  logic [5:0]         yw,
  input  logic [5:0]         align,
  input  logic [OFF_W-1:0]   xmask,
  input  logic [OFF_W-1:0]   ymask,
  output logic               range_bad,
  output logic [OFF_W-1:0]   offset
);
  logic [OFF_W-1:0] xe, ye, xm, ym, lin;

  always_comb begin
    xe = {{(OFF_W-COORD_W){1'b0}}, x_in};
    ye = {{(OFF_W-COORD_W){1'b0}}, y_in};
    range_bad = (xe > xmask) || (ye > ymask);
    // mirror within the format's own coordinate width
    xm = orient[0] ? (xe ^ xmask) : xe;
    ym = orient[1] ? (ye ^ ymask) : ye;
    // row-major on the chosen major axis
    lin = orient[2] ? ((xm << yw) + ym) : ((ym << xw) + xm);
    offset = lin << align;
  end
endmodule

// File: rtl/tv_stride_slot.sv
module tv_stride_slot #(
  parameter int CW_BITS = 14,
  parameter int CH_BITS = 13,
  parameter int SW_BITS = 6,
  parameter int SH_BITS = 6,
  parameter int STR_W   = 32
) (
  input  logic                       flip,
  input  logic [5:0]                 ux,
  input  logic [5:0]                 uy,
  input  logic [CW_BITS-SW_BITS-1:0] slot_x,
  input  logic [CH_BITS-SH_BITS-1:0] slot_y,
  output logic [STR_W-1:0]           stride,
  output logic [CW_BITS-1:0]         pix_x,
  output logic [CH_BITS-1:0]         pix_y
);
  always_comb begin
    stride = flip ? (STR_W'(1) << (6'(CH_BITS) + ux))
                  : (STR_W'(1) << (6'(CW_BITS) + uy));
    pix_x  = CW_BITS'(slot_x) << (6'(SW_BITS) - ux);
    pix_y  = CH_BITS'(slot_y) << (6'(SH_BITS) - uy);
  end
endmodule

// File: rtl/tv_addr_gen.sv
module tv_addr_gen #(
  parameter int COORD_W = 16,
  parameter int CW_BITS = 14,
  parameter int CH_BITS = 13,
  parameter int SW_BITS = 6,
  parameter int SH_BITS = 6,
  parameter int STR_W   = 32
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           in_valid,
  input  logic [1:0]                     fmt,
  input  logic [2:0]                     orient,
  input  logic [COORD_W-1:0]             x_in,
  input  logic [COORD_W-1:0]             y_in,
  input  logic [CW_BITS-SW_BITS-1:0]     slot_x,
  input  logic [CH_BITS-SH_BITS-1:0]     slot_y,
  output logic                           out_valid,
  output logic [CW_BITS+CH_BITS+4:0]     addr,
  output logic                           coord_err,
  output logic [STR_W-1:0]               stride,
  output logic [CW_BITS-1:0]             pix_x,
  output logic [CH_BITS-1:0]             pix_y
);
  localparam int OFF_W  = CW_BITS + CH_BITS;
  localparam int ADDR_W = OFF_W + 5;

  logic [5:0]       ux, uy, xw, yw, align;
  logic [OFF_W-1:0] xmask, ymask, offset;
  logic             range_bad;
  logic [ADDR_W-1:0] addr_next;
  logic [STR_W-1:0]  stride_next;
  logic [CW_BITS-1:0] pix_x_next;
  logic [CH_BITS-1:0] pix_y_next;

  tv_geom #(.CW_BITS(CW_BITS), .CH_BITS(CH_BITS), .SW_BITS(SW_BITS), .SH_BITS(SH_BITS)) u_geom (
    .fmt(fmt), .ux(ux), .uy(uy), .xw(xw), .yw(yw), .align(align),
    .xmask(xmask), .ymask(ymask)
  );

  tv_coord_map #(.COORD_W(COORD_W), .CW_BITS(CW_BITS), .CH_BITS(CH_BITS)) u_map (
    .x_in(x_in), .y_in(y_in), .orient(orient), .xw(xw), .yw(yw), .align(align),
    .xmask(xmask), .ymask(ymask), .range_bad(range_bad), .offset(offset)
  );

  tv_stride_slot #(.CW_BITS(CW_BITS), .CH_BITS(CH_BITS), .SW_BITS(SW_BITS),
                   .SH_BITS(SH_BITS), .STR_W(STR_W)) u_str (
    .flip(orient[2]), .ux(ux), .uy(uy), .slot_x(slot_x), .slot_y(slot_y),
    .stride(stride_next), .pix_x(pix_x_next), .pix_y(pix_y_next)
  );

  assign addr_next = range_bad ? '0 : {orient, fmt, offset};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      addr      <= '0;
      coord_err <= 1'b0;
      stride    <= '0;
      pix_x     <= '0;
      pix_y     <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        addr      <= addr_next;
        coord_err <= range_bad;
        stride    <= stride_next;
        pix_x     <= pix_x_next;
        pix_y     <= pix_y_next;
      end
    end
  end
endmodule

// File: rtl/tv_addr_gen_chk.sv
module tv_addr_gen_chk #(
  parameter int ADDR_W = 32,
  parameter int STR_W  = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [1:0]        fmt,
  input logic [2:0]        orient,
  input logic              range_bad,
  input logic              out_valid,
  input logic [ADDR_W-1:0] addr,
  input logic              coord_err,
  input logic [STR_W-1:0]  stride
);
  a_r1_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  a_r1_valid_drops: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  a_r3_err_zero_addr: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && coord_err |-> addr == '0);
  a_r3_err_tracks_check: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> coord_err == $past(range_bad));
  a_r2_top_fields: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !range_bad |=>
      addr[ADDR_W-1 -: 3] == $past(orient) && addr[ADDR_W-4 -: 2] == $past(fmt));
  a_r6_word_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !range_bad && fmt == 2'd2 |=> addr[1:0] == 2'b00);
  a_r7_stride_pow2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $countones(stride) == 1);
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(addr) && $stable(stride) && $stable(coord_err));
endmodule

bind tv_addr_gen tv_addr_gen_chk #(.ADDR_W(ADDR_W), .STR_W(STR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .fmt(fmt), .orient(orient),
  .range_bad(range_bad), .out_valid(out_valid), .addr(addr),
  .coord_err(coord_err), .stride(stride)
);

// File: tb/sim_tv_addr_gen.sv
module sim_tv_addr_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [1:0]  fmt = '0;
  logic [2:0]  orient = '0;
  logic [15:0] x_in = '0, y_in = '0;
  logic [7:0]  slot_x = '0;
  logic [6:0]  slot_y = '0;
  logic        out_valid, coord_err;
  logic [31:0] addr, stride;
  logic [13:0] pix_x;
  logic [12:0] pix_y;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  tv_addr_gen u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .fmt(fmt), .orient(orient),
    .x_in(x_in), .y_in(y_in), .slot_x(slot_x), .slot_y(slot_y),
    .out_valid(out_valid), .addr(addr), .coord_err(coord_err), .stride(stride),
    .pix_x(pix_x), .pix_y(pix_y)
  );

  typedef struct packed {
    logic [1:0]  f;
    logic [2:0]  o;
    logic [15:0] x;
    logic [15:0] y;
    logic [7:0]  sx;
    logic [6:0]  sy;
    logic [31:0] ea;
    logic        ee;
    logic [31:0] es;
    logic [13:0] epx;
    logic [12:0] epy;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 3'd0, 16'h0005, 16'h0003, 8'd3,   7'd2,   32'h0000C005, 1'b0, 32'h00004000, 14'd192,   13'd128},
    '{2'd1, 3'd0, 16'h0005, 16'h0003, 8'd3,   7'd2,   32'h0801800A, 1'b0, 32'h00008000, 14'd192,   13'd64},
    '{2'd2, 3'd0, 16'h0005, 16'h0003, 8'd3,   7'd2,   32'h10018014, 1'b0, 32'h00008000, 14'd96,    13'd64},
    '{2'd0, 3'd1, 16'h0005, 16'h0003, 8'd3,   7'd2,   32'h2000FFFA, 1'b0, 32'h00004000, 14'd192,   13'd128},
    '{2'd0, 3'd2, 16'h0005, 16'h0003, 8'd3,   7'd2,   32'h47FF0005, 1'b0, 32'h00004000, 14'd192,   13'd128},
    '{2'd0, 3'd4, 16'h0005, 16'h0003, 8'd3,   7'd2,   32'h8000A003, 1'b0, 32'h00002000, 14'd192,   13'd128},
    '{2'd3, 3'd0, 16'h0005, 16'h0003, 8'd3,   7'd2,   32'h18305000, 1'b0, 32'h00100000, 14'd3,     13'd2},
    '{2'd0, 3'd0, 16'h3FFF, 16'h1FFF, 8'd255, 7'd127, 32'h07FFFFFF, 1'b0, 32'h00004000, 14'd16320, 13'd8128},
    '{2'd0, 3'd0, 16'h4000, 16'h0000, 8'd3,   7'd2,   32'h00000000, 1'b1, 32'h00004000, 14'd192,   13'd128},
    '{2'd2, 3'd0, 16'h2000, 16'h0000, 8'd3,   7'd2,   32'h00000000, 1'b1, 32'h00008000, 14'd96,    13'd64},
    '{2'd1, 3'd0, 16'h0000, 16'h1000, 8'd3,   7'd2,   32'h00000000, 1'b1, 32'h00008000, 14'd192,   13'd64},
    '{2'd2, 3'd7, 16'h0005, 16'h0003, 8'd3,   7'd2,   32'hF7FEBFF0, 1'b0, 32'h00004000, 14'd96,    13'd64},
    '{2'd3, 3'd4, 16'h0005, 16'h0003, 8'd3,   7'd2,   32'h98283000, 1'b0, 32'h00080000, 14'd3,     13'd2},
    '{2'd1, 3'd3, 16'h0000, 16'h0000, 8'd3,   7'd2,   32'h6FFFFFFE, 1'b0, 32'h00008000, 14'd192,   13'd64}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic drive(input vec_t v, input logic vld);
    fmt = v.f; orient = v.o; x_in = v.x; y_in = v.y;
    slot_x = v.sx; slot_y = v.sy; in_valid = vld;
  endtask

  task automatic check_vec(input int i, input vec_t v);
    check($sformatf("R1 out_valid vec %0d", i), 32'(out_valid), 32'd1);
    check($sformatf("R2 R3 R4 R5 R6 addr vec %0d", i), addr, v.ea);
    check($sformatf("R3 coord_err vec %0d", i), 32'(coord_err), 32'(v.ee));
    check($sformatf("R7 stride vec %0d", i), stride, v.es);
    check($sformatf("R8 pix_x vec %0d", i), 32'(pix_x), 32'(v.epx));
    check($sformatf("R8 pix_y vec %0d", i), 32'(pix_y), 32'(v.epy));
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (4000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL R1 watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    // R9: reset state, with a request presented during reset
    drive(VECS[0], 1'b1);
    repeat (3) @(negedge clk);
    check("R9 out_valid in reset", 32'(out_valid), 32'd0);
    check("R9 addr in reset", addr, 32'd0);
    check("R9 stride in reset", stride, 32'd0);
    check("R9 pix in reset", {5'd0, pix_x, pix_y}, 32'd0);
    in_valid = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 no valid without request", 32'(out_valid), 32'd0);

    // table walk: one request, then one idle cycle
    for (int i = 0; i < NV; i++) begin
      drive(VECS[i], 1'b1);
      @(negedge clk);
      check_vec(i, VECS[i]);
      in_valid = 1'b0;
      @(negedge clk);
      check($sformatf("R1 valid drops vec %0d", i), 32'(out_valid), 32'd0);
    end

    // R10: new inputs without a strobe leave last results (vector 13) in place
    drive(VECS[5], 1'b0);
    repeat (2) @(negedge clk);
    check("R10 addr held", addr, VECS[13].ea);
    check("R10 stride held", stride, VECS[13].es);
    check("R10 pix_x held", 32'(pix_x), 32'(VECS[13].epx));
    check("R1 no valid while idle", 32'(out_valid), 32'd0);

    // R1: back-to-back requests, each result one cycle later
    drive(VECS[6], 1'b1);
    @(negedge clk);
    check_vec(6, VECS[6]);
    drive(VECS[8], 1'b1);
    @(negedge clk);
    check_vec(8, VECS[8]);
    drive(VECS[11], 1'b1);
    @(negedge clk);
    check_vec(11, VECS[11]);
    in_valid = 1'b0;
    @(negedge clk);
    check("R1 valid drops after burst", 32'(out_valid), 32'd0);
    check("R10 err held after burst", 32'(coord_err), 32'd0);

    // R3: error result held while idle, then cleared by an in-range request
    drive(VECS[9], 1'b1);
    @(negedge clk);
    check("R3 error flagged at edge", 32'(coord_err), 32'd1);
    drive(VECS[2], 1'b0);
    @(negedge clk);
    check("R10 error flag held", 32'(coord_err), 32'd1);
    check("R10 zero addr held", addr, 32'd0);

    // R9: reset in mid-run clears results
    rst_n = 1'b0;
    #3;
    check("R9 async reset addr", addr, 32'd0);
    check("R9 async reset err", 32'(coord_err), 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    finish_run();
  end
endmodule